// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic unit for an 8-bit accumulator machine. In a single cycle it combines an accumulator value, an operand and the incoming carry flag under a 4-bit operation select. It returns a result, the four condition flags (negative, overflow, zero, carry) and a mask of the flags that the selected operation is allowed to change.

Several operations produce flags without producing a new accumulator value. For compare and bit test, the result port returns the accumulator unchanged. For test-and-set and test-and-reset, the result is the modified memory byte, and the zero flag reports the overlap between the accumulator and that byte.

A status byte register keeps the flags from one operation to the next. When the commit input is high, only the flags named in the update mask are loaded into it. Unary operations (increment, decrement, shifts, rotates) act on the accumulator input. Decimal arithmetic, operand fetch and decode are handled elsewhere.

Top module: `alu8_flags`

## Requirements
- R1: Op 0 (add) gives res = acc + opnd + cin modulo 256. C is the ninth sum bit. V is set when acc and opnd share bit 7 and res bit 7 differs from it. N, V, Z and C are updated.
- R2: Op 1 (subtract) gives res = acc - opnd - (1 - cin). C is set when no borrow occurs, and V is the add rule applied to the inverted operand. Op 5 (compare) computes acc - opnd, updates N, Z and C, leaves V alone and returns acc on res.
- R3: Ops 2 (AND), 3 (OR), 4 (XOR) and 15 (load, res = opnd) update only N and Z.
- R4: Op 6 (increment, acc+1) and op 7 (decrement, acc-1) wrap modulo 256 and update only N and Z, never C.
- R5: Op 8 (shift left) moves acc bit 7 into C and fills bit 0 with 0. Op 9 (shift right) moves acc bit 0 into C, fills bit 7 with 0 and always clears N. Both update N, Z and C.
- R6: Op 10 (rotate left) and op 11 (rotate right) pass cin in as the ninth bit at the vacated end and put the bit shifted out into C. They update N, Z and C.
- R7: Op 12 (bit test) sets Z when acc AND opnd is zero, copies opnd bit 7 to N and bit 6 to V, updates only N, V and Z, and returns acc on res.
- R8: Op 13 (test-and-set) returns acc OR opnd. Op 14 (test-and-reset) returns (NOT acc) AND opnd. For both, Z is set when acc AND opnd is zero, and only Z is updated.
- R9: Wherever N and Z are produced from res, N is res bit 7 and Z is set exactly when res is zero. Flags and mask are packed as {N,V,Z,C}, bit 3 down to bit 0.
- R10: The status byte holds N at bit 7, V at bit 6, Z at bit 1 and C at bit 0, with the other bits zero. It resets to 0. On a clock edge with commit high, only the bits whose mask bit is set take the new flags. With commit low, it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the status byte |
| commit | input | 1 | Load masked flags into the status byte at the edge |
| op | input | 4 | Operation select |
| acc | input | 8 | Accumulator value |
| opnd | input | 8 | Operand / memory byte |
| cin | input | 1 | Incoming carry flag |
| res | output | 8 | Operation result |
| flags | output | 4 | New flags {N,V,Z,C} |
| upd | output | 4 | Flags this operation updates {N,V,Z,C} |
| status | output | 8 | Registered status byte |

## Verification
The bench builds the block at its only width of 8 bits. Because the datapath is combinational, it can sweep every accumulator and operand pair, with both carry values, for add, subtract and compare. That sweep reaches every signed-overflow and borrow corner, including 0x7F+1 and 0x80-1. The other operations are swept over all accumulator values against 16 operand values spread from 0x00 to 0xFF. A short clocked sequence then exercises masked commits of the status byte, commit held low, and reset.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  logic [3:0]   op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic [3:0]   flags,
  output logic [3:0]   upd,
  output logic [7:0]   status
);
  localparam int MSB = W - 1;
  localparam logic [3:0] OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_AND = 4'd2,  OP_OR  = 4'd3,
                         OP_XOR = 4'd4,  OP_CMP = 4'd5,  OP_INC = 4'd6,  OP_DEC = 4'd7,
                         OP_SHL = 4'd8,  OP_SHR = 4'd9,  OP_ROL = 4'd10, OP_ROR = 4'd11,
                         OP_BIT = 4'd12, OP_TSB = 4'd13, OP_TRB = 4'd14, OP_LD  = 4'd15;
  localparam logic [3:0] M_NZ = 4'b1010, M_NZC = 4'b1011, M_ALL = 4'b1111,
                         M_NVZ = 4'b1110, M_Z = 4'b0010;

  logic         sub_mode;
  logic [W-1:0] addend;
  logic         carry_in;
  logic [W:0]   sum;
  logic         ovf;
  logic [W-1:0] anded;
  logic         n_f, v_f, z_f, c_f;

  assign sub_mode = (op == OP_SUB) || (op == OP_CMP);
  assign addend   = sub_mode ? ~opnd : opnd;
  assign carry_in = (op == OP_CMP) ? 1'b1 : cin;
  assign sum      = {1'b0, acc} + {1'b0, addend} + {{W{1'b0}}, carry_in};
  assign ovf      = (acc[MSB] == addend[MSB]) && (sum[MSB] != acc[MSB]);
  assign anded    = acc & opnd;

  always_comb begin
    res = acc;
    upd = M_NZ;
    c_f = cin;
    v_f = 1'b0;
    case (op)
      OP_ADD, OP_SUB: begin res = sum[MSB:0]; c_f = sum[W]; v_f = ovf; upd = M_ALL; end
      OP_AND: res = anded;
      OP_OR:  res = acc | opnd;
      OP_XOR: res = acc ^ opnd;
      OP_CMP: begin c_f = sum[W]; upd = M_NZC; end
      OP_INC: res = acc + 1'b1;
      OP_DEC: res = acc - 1'b1;
      OP_SHL: begin res = {acc[MSB-1:0], 1'b0}; c_f = acc[MSB]; upd = M_NZC; end
      OP_SHR: begin res = {1'b0, acc[MSB:1]};   c_f = acc[0];   upd = M_NZC; end
      OP_ROL: begin res = {acc[MSB-1:0], cin};  c_f = acc[MSB]; upd = M_NZC; end
      OP_ROR: begin res = {cin, acc[MSB:1]};    c_f = acc[0];   upd = M_NZC; end
      OP_BIT: begin v_f = opnd[MSB-1]; upd = M_NVZ; end
      OP_TSB: begin res = acc | opnd;  upd = M_Z; end
      OP_TRB: begin res = ~acc & opnd; upd = M_Z; end
      default: res = opnd;
    endcase
  end

  always_comb begin
    n_f = res[MSB];
    z_f = (res == '0);
    case (op)
      OP_CMP:         begin n_f = sum[MSB]; z_f = (sum[MSB:0] == '0); end
      OP_BIT:         begin n_f = opnd[MSB]; z_f = (anded == '0); end
      OP_TSB, OP_TRB: z_f = (anded == '0);
      default: ;
    endcase
  end

  assign flags = {n_f, v_f, z_f, c_f};

  always_ff @(posedge clk) begin
    if (!rst_n) status <= 8'h00;
    else if (commit) begin
      if (upd[3]) status[7] <= n_f;
      if (upd[2]) status[6] <= v_f;
      if (upd[1]) status[1] <= z_f;
      if (upd[0]) status[0] <= c_f;
    end
  end

  a_r10_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(status));
  a_r10_carry_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !upd[0]) |=> status[0] == $past(status[0]));
  a_r10_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[5:2] == 4'b0000);
  a_r4_no_carry_update: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC || op == OP_DEC) |-> !upd[0] && !upd[2]);
  a_r5_shr_clears_n: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHR) |-> !flags[3]);
  a_r7_acc_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BIT || op == OP_CMP) |-> res == acc);
  a_r8_z_only: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_TSB || op == OP_TRB) |-> upd == 4'b0010);
endmodule

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       commit = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] acc = 8'd0, opnd = 8'd0;
  logic       cin = 1'b0;
  logic [7:0] res;
  logic [3:0] flags, upd;
  logic [7:0] status;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  alu8_flags #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .commit(commit), .op(op), .acc(acc), .opnd(opnd),
    .cin(cin), .res(res), .flags(flags), .upd(upd), .status(status)
  );

  always #5 clk = ~clk;

  function automatic string req_of(input int o);
    case (o)
      0: return "R1";
      1, 5: return "R2";
      2, 3, 4, 15: return "R3";
      6, 7: return "R4";
      8, 9: return "R5";
      10, 11: return "R6";
      12: return "R7";
      default: return "R8";
    endcase
  endfunction

  // returns {res[7:0], flags[3:0], upd[3:0]}
  function automatic logic [15:0] model(input int o, input int a, input int b, input int c);
    int r, n, v, z, cf, m, t;
    r = a; v = 0; cf = c; m = 4'b1010;
    case (o)
      0: begin t = a + b + c; r = t % 256; cf = t / 256;
               v = ((a >= 128) == (b >= 128) && (r >= 128) != (a >= 128)) ? 1 : 0; m = 15; end
      1: begin t = a - b - (1 - c); cf = (t >= 0) ? 1 : 0; r = (t + 512) % 256;
               v = ((a >= 128) != (b >= 128) && (r >= 128) != (a >= 128)) ? 1 : 0; m = 15; end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: begin t = a - b; cf = (t >= 0) ? 1 : 0; m = 4'b1011; end
      6: r = (a + 1) % 256;
      7: r = (a + 255) % 256;
      8: begin r = (a * 2) % 256; cf = a / 128; m = 4'b1011; end
      9: begin r = a / 2; cf = a % 2; m = 4'b1011; end
      10: begin r = (a * 2) % 256 + c; cf = a / 128; m = 4'b1011; end
      11: begin r = a / 2 + c * 128; cf = a % 2; m = 4'b1011; end
      12: begin v = (b / 64) % 2; m = 4'b1110; end
      13: begin r = a | b; m = 4'b0010; end
      14: begin r = (~a) & b & 255; m = 4'b0010; end
      default: r = b;
    endcase
    n = (r >= 128) ? 1 : 0;
    z = (r == 0) ? 1 : 0;
    if (o == 5) begin t = (a - b + 256) % 256; n = (t >= 128) ? 1 : 0; z = (t == 0) ? 1 : 0; end
    if (o == 12) n = b / 128;
    if (o >= 12 && o <= 14) z = ((a & b) == 0) ? 1 : 0;
    model = {r[7:0], n[0], v[0], z[0], cf[0], m[3:0]};
  endfunction

  task automatic check(input string rq, input string what, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s op=%0d acc=%h opnd=%h cin=%0d: actual %h expected %h",
               rq, what, op, acc, opnd, cin, got, exp);
    end
  endtask

  task automatic apply(input int o, input int a, input int b, input int c);
    op = o[3:0]; acc = a[7:0]; opnd = b[7:0]; cin = c[0];
    #1;
    check(req_of(o), "comb", {res, flags, upd}, model(o, a, b, c));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_st;
    logic [15:0] mv;
    repeat (2) @(negedge clk);
    check("R10", "reset status", {8'h00, status}, 16'h0000);
    rst_n = 1'b1;

    // R1 R2 exhaustive add, subtract, compare
    for (int o = 0; o < 6; o += 1) begin
      if (o == 0 || o == 1 || o == 5)
        for (int a = 0; a < 256; a++)
          for (int b = 0; b < 256; b++)
            for (int c = 0; c < 2; c++) apply(o, a, b, c);
    end
    // R3..R8 and R9 over all acc, spread operands
    for (int o = 2; o < 16; o++) begin
      if (o != 5)
        for (int a = 0; a < 256; a++)
          for (int b = 0; b < 256; b += 17)
            for (int c = 0; c < 2; c++) apply(o, a, b, c);
    end
    // R1 corner: 0x7F + 0x01 overflows
    apply(0, 8'h7F, 8'h01, 0);
    check("R1", "overflow flag", {15'd0, flags[2]}, 16'd1);
    // R2 corner: 0x80 - 1 overflows
    apply(1, 8'h80, 8'h01, 1);
    check("R2", "overflow flag", {15'd0, flags[2]}, 16'd1);

    // R10 masked commits
    exp_st = 8'h00;
    @(negedge clk);
    op = 4'd0; acc = 8'hFF; opnd = 8'h01; cin = 1'b0; commit = 1'b1; // Z=1 C=1
    mv = model(0, 255, 1, 0);
    @(negedge clk);
    exp_st = {mv[7], mv[6], 4'b0000, mv[5], mv[4]};
    check("R10", "commit add", {8'h00, status}, {8'h00, exp_st});
    op = 4'd6; acc = 8'h7F; // INC -> N=1 Z=0, C kept
    mv = model(6, 127, 1, 0);
    @(negedge clk);
    exp_st[7] = mv[7]; exp_st[1] = mv[5];
    check("R10", "commit inc keeps C and V", {8'h00, status}, {8'h00, exp_st});
    op = 4'd12; acc = 8'h00; opnd = 8'h40; // BIT: N=0 V=1 Z=1
    @(negedge clk);
    exp_st[7] = 1'b0; exp_st[6] = 1'b1; exp_st[1] = 1'b1;
    check("R10", "commit bit test", {8'h00, status}, {8'h00, exp_st});
    commit = 1'b0; op = 4'd0; acc = 8'h01; opnd = 8'h01;
    repeat (2) @(negedge clk);
    check("R10", "hold without commit", {8'h00, status}, {8'h00, exp_st});
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", "reset clears", {8'h00, status}, 16'h0000);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule